// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block owns the refresh and power behaviour of an external SDRAM. It sits beside the read/write access engine and shares the command, address and clock-enable pins with it. It keeps a running count of rows that are owed a refresh. Once the count reaches the selected burst size, it issues that many auto-refresh commands back to back. If any row is open, it closes all banks first. While refresh work is pending or in progress, it holds back the access grant.

Software can place the device in self-refresh with a single pulse. The device leaves self-refresh without further software action as soon as the access engine raises a request. A warm-reset request can be made to put the device into self-refresh before the acknowledge that lets the reset proceed is given. When power-down is enabled and nothing is pending, clock enable is dropped and the block reports idle. A mode-load pulse writes the stored mode value onto the address pins, issued either as a normal or as an extended mode-register command.

Top module: `sdram_pwr_seq`

## Requirements
- R1: After synchronous reset, sd_cmd is NOP, sd_cke is 1, and acc_grant, refresh_busy, rst_ack and idle are 0. The sd_cmd codes are: NOP=0, precharge-all=1, refresh=2, mode load=3, extended mode load=4.
- R2: cfg_burst_sel picks the rows per refresh burst: 00 gives 1, 01 gives 4, 10 or 11 gives 8. A burst issues that many refresh commands spaced exactly TRFC cycles apart. refresh_busy is 1 whenever a refresh command is on the pins with sd_cke high.
- R3: One row becomes owed every ROW_INT_CYC cycles. A burst starts once the rows owed reach the burst size, so the first commands of consecutive bursts are ROW_INT_CYC times the burst size apart.
- R4: If bank_open is 1 when refresh work starts, a precharge-all with address bit AP_BIT set comes first. The refresh follows exactly TRP cycles later.
- R5: While refresh work is pending or refresh_busy is 1, acc_grant stays 0 even with acc_req held. When there is nothing to do, acc_req is granted.
- R6: A pulse on sw_sref_set issues a refresh command with sd_cke low in the same cycle. sd_cke then stays low, and no refresh is issued while the device self-refreshes.
- R7: In software self-refresh, acc_req raises sd_cke in the next cycle. The first acc_grant follows TXSR+1 cycles after sd_cke rises.
- R8: With cfg_rst_protect=1, warm_rst_req enters self-refresh, with a precharge first if a bank is open. rst_ack rises one cycle after the self-refresh command and then holds. acc_req does not wake this self-refresh.
- R9: With cfg_rst_protect=0, warm_rst_req raises rst_ack in the next cycle, with no command and sd_cke held high.
- R10: With cfg_pd_en=1 and nothing pending, sd_cke drops and idle rises. acc_req raises sd_cke and clears idle in the next cycle, and the grant follows one cycle later.
- R11: A mode_load pulse issues a mode command with sd_addr equal to mode_reg_val: code 3 if cfg_emrs_sel=0, code 4 if it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_sel | input | 2 | Rows per refresh burst select |
| cfg_rst_protect | input | 1 | Enter self-refresh before acknowledging a warm reset |
| cfg_pd_en | input | 1 | Allow power-down when nothing is pending |
| cfg_emrs_sel | input | 1 | Issue mode loads as extended mode commands |
| sw_sref_set | input | 1 | Pulse: request software self-refresh |
| mode_load | input | 1 | Pulse: request a mode-register load |
| mode_reg_val | input | ADDR_W | Value placed on the address pins by a mode load |
| acc_req | input | 1 | Access engine wants the SDRAM |
| bank_open | input | 1 | Some row is currently open |
| warm_rst_req | input | 1 | Warm reset requested |
| acc_grant | output | 1 | Access engine may issue commands |
| refresh_busy | output | 1 | Refresh burst in progress |
| rst_ack | output | 1 | Warm reset may be applied |
| idle | output | 1 | Interface is in power-down |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cmd | output | 3 | SDRAM command code |
| sd_addr | output | ADDR_W | SDRAM address pins |

## Verification
Refresh is tried with one-row bursts and four-row bursts on closed banks. The gaps between commands separate the per-command spacing from the burst-to-burst rate, and a wrong row count shifts every later gap. An eight-row burst with an open bank and a held access request shows whether the precharge comes first, whether its spacing is right, and whether the grant is withheld. Self-refresh entered by software is set against self-refresh entered for a warm reset. Access is expected to wake the first and not the second. Power-down and both mode-load codes are each driven from a fresh reset, and any refresh command that shows up in the middle counts as unexpected.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_PRE_ALL  = 3'd1,
    CMD_REFRESH  = 3'd2,
    CMD_MODE     = 3'd3,
    CMD_EXT_MODE = 3'd4
  } sd_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE_W,
    S_REF_W,
    S_MODE_W,
    S_SELF,
    S_EXIT_W,
    S_PD,
    S_ACK
  } seq_state_e;

  typedef enum logic [1:0] {
    TGT_REF,
    TGT_SELF,
    TGT_RST,
    TGT_MODE
  } seq_tgt_e;

  function automatic logic [3:0] burst_rows(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd1;
      2'b01:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sdram_row_credit.sv
module sdram_row_credit #(
  parameter int ROW_INT_CYC = 390,
  parameter int MAX_OWED    = 16,
  parameter int CW          = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          dec,
  input  logic [CW-1:0] need,
  output logic          due
);
  localparam int IW = (ROW_INT_CYC > 1) ? $clog2(ROW_INT_CYC) : 1;

  logic [IW-1:0] cnt;
  logic [CW-1:0] owed;
  logic [CW-1:0] owed_n;
  logic [CW:0]   sum;
  logic          tick;

  assign tick = (cnt == IW'(ROW_INT_CYC - 1));

  always_comb begin
    sum = {1'b0, owed} + {{CW{1'b0}}, tick};
    if (dec)
      sum = (sum >= {1'b0, need}) ? (sum - {1'b0, need}) : '0;
    if (sum > (CW+1)'(MAX_OWED))
      sum = (CW+1)'(MAX_OWED);
    owed_n = sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      owed <= '0;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      owed <= owed_n;
    end
  end

  assign due = (need != '0) && (owed >= need);

endmodule

// File: rtl/sdram_wait_ctr.sv
module sdram_wait_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_pwr_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int AP_BIT      = 10,
  parameter int ROW_INT_CYC = 390,
  parameter int MAX_OWED    = 16,
  parameter int TRP         = 3,
  parameter int TRFC        = 7,
  parameter int TXSR        = 8,
  parameter int TMRD        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_burst_sel,
  input  logic              cfg_rst_protect,
  input  logic              cfg_pd_en,
  input  logic              cfg_emrs_sel,
  input  logic              sw_sref_set,
  input  logic              mode_load,
  input  logic [ADDR_W-1:0] mode_reg_val,
  input  logic              acc_req,
  input  logic              bank_open,
  input  logic              warm_rst_req,
  output logic              acc_grant,
  output logic              refresh_busy,
  output logic              rst_ack,
  output logic              idle,
  output logic              sd_cke,
  output logic [2:0]        sd_cmd,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int T1   = (TRP > TRFC) ? TRP : TRFC;
  localparam int T2   = (TXSR > TMRD) ? TXSR : TMRD;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int WW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(MAX_OWED + 1);
  localparam logic [ADDR_W-1:0] PRE_ADDR =
    (AP_BIT < ADDR_W) ? (ADDR_W'(1) << AP_BIT) : '0;

  seq_state_e        state, n_state;
  seq_tgt_e          tgt, n_tgt;
  sd_cmd_e           cmd_q, n_cmd;
  logic [ADDR_W-1:0] addr_q, n_addr;
  logic              cke_q, n_cke;
  logic              busy_q, n_busy;
  logic              grant_q, n_grant;
  logic              rack_q, n_rack;
  logic              idle_q, n_idle;
  logic [2:0]        rows_left, n_rows;
  logic              sr_sw, n_srsw;
  logic              mrs_pend, n_mrsp;
  logic              sr_keep, n_keep;

  logic              wl;
  logic [WW-1:0]     wv;
  logic              wzero;
  logic              done_c;
  logic              due;
  logic [3:0]        blen;
  logic              start;
  seq_tgt_e          start_tgt;
  logic              fire;
  seq_tgt_e          fire_tgt;
  logic              wake_pd;

  assign blen = burst_rows(cfg_burst_sel);

  sdram_row_credit #(
    .ROW_INT_CYC(ROW_INT_CYC),
    .MAX_OWED   (MAX_OWED),
    .CW         (CW)
  ) u_credit (
    .clk (clk),
    .rst (rst),
    .clr (state == S_SELF),
    .dec (done_c),
    .need(CW'(blen)),
    .due (due)
  );

  sdram_wait_ctr #(.W(WW)) u_wait (
    .clk (clk),
    .rst (rst),
    .load(wl),
    .val (wv),
    .zero(wzero)
  );

  assign wake_pd = warm_rst_req | due | sr_sw | mrs_pend | acc_req | ~cfg_pd_en;

  always_comb begin
    n_state   = state;
    n_tgt     = tgt;
    n_cmd     = CMD_NOP;
    n_addr    = addr_q;
    n_cke     = cke_q;
    n_busy    = busy_q;
    n_grant   = 1'b0;
    n_rack    = rack_q;
    n_idle    = idle_q;
    n_rows    = rows_left;
    n_srsw    = sr_sw | sw_sref_set;
    n_mrsp    = mrs_pend | mode_load;
    n_keep    = sr_keep;
    wl        = 1'b0;
    wv        = '0;
    done_c    = 1'b0;
    start     = 1'b0;
    start_tgt = TGT_REF;
    fire      = 1'b0;
    fire_tgt  = tgt;

    case (state)
      S_IDLE: begin
        if (warm_rst_req) begin
          if (cfg_rst_protect) begin
            start     = 1'b1;
            start_tgt = TGT_RST;
          end else begin
            n_rack  = 1'b1;
            n_state = S_ACK;
          end
        end else if (due) begin
          n_busy    = 1'b1;
          start     = 1'b1;
          start_tgt = TGT_REF;
        end else if (sr_sw) begin
          start     = 1'b1;
          start_tgt = TGT_SELF;
        end else if (mrs_pend) begin
          start     = 1'b1;
          start_tgt = TGT_MODE;
        end else if (acc_req) begin
          n_grant = 1'b1;
        end else if (cfg_pd_en) begin
          n_cke   = 1'b0;
          n_idle  = 1'b1;
          n_state = S_PD;
        end
      end
      S_PRE_W: begin
        if (wzero) begin
          fire     = 1'b1;
          fire_tgt = tgt;
        end
      end
      S_REF_W: begin
        if (wzero) begin
          if (rows_left != 3'd0) begin
            n_rows = rows_left - 3'd1;
            n_cmd  = CMD_REFRESH;
            n_addr = '0;
            wl     = 1'b1;
            wv     = WW'(TRFC - 1);
          end else begin
            n_busy  = 1'b0;
            done_c  = 1'b1;
            n_state = S_IDLE;
          end
        end
      end
      S_MODE_W: begin
        if (wzero)
          n_state = S_IDLE;
      end
      S_SELF: begin
        n_rack = sr_keep;
        if (!sr_keep && acc_req) begin
          n_cke   = 1'b1;
          wl      = 1'b1;
          wv      = WW'(TXSR - 1);
          n_state = S_EXIT_W;
        end
      end
      S_EXIT_W: begin
        if (wzero)
          n_state = S_IDLE;
      end
      S_PD: begin
        if (wake_pd) begin
          n_cke   = 1'b1;
          n_idle  = 1'b0;
          n_state = S_IDLE;
        end
      end
      S_ACK: begin
        n_rack = 1'b1;
      end
      default: n_state = S_IDLE;
    endcase

    if (start) begin
      if (bank_open) begin
        n_cmd   = CMD_PRE_ALL;
        n_addr  = PRE_ADDR;
        n_tgt   = start_tgt;
        wl      = 1'b1;
        wv      = WW'(TRP - 1);
        n_state = S_PRE_W;
      end else begin
        fire     = 1'b1;
        fire_tgt = start_tgt;
      end
    end

    if (fire) begin
      case (fire_tgt)
        TGT_REF: begin
          n_cmd   = CMD_REFRESH;
          n_addr  = '0;
          n_rows  = 3'(blen - 4'd1);
          wl      = 1'b1;
          wv      = WW'(TRFC - 1);
          n_state = S_REF_W;
        end
        TGT_SELF, TGT_RST: begin
          n_cmd   = CMD_REFRESH;
          n_addr  = '0;
          n_cke   = 1'b0;
          n_keep  = (fire_tgt == TGT_RST);
          if (fire_tgt == TGT_SELF)
            n_srsw = sw_sref_set;
          n_state = S_SELF;
        end
        default: begin
          n_cmd   = cfg_emrs_sel ? CMD_EXT_MODE : CMD_MODE;
          n_addr  = mode_reg_val;
          n_mrsp  = mode_load;
          wl      = 1'b1;
          wv      = WW'(TMRD - 1);
          n_state = S_MODE_W;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      tgt       <= TGT_REF;
      cmd_q     <= CMD_NOP;
      addr_q    <= '0;
      cke_q     <= 1'b1;
      busy_q    <= 1'b0;
      grant_q   <= 1'b0;
      rack_q    <= 1'b0;
      idle_q    <= 1'b0;
      rows_left <= '0;
      sr_sw     <= 1'b0;
      mrs_pend  <= 1'b0;
      sr_keep   <= 1'b0;
    end else begin
      state     <= n_state;
      tgt       <= n_tgt;
      cmd_q     <= n_cmd;
      addr_q    <= n_addr;
      cke_q     <= n_cke;
      busy_q    <= n_busy;
      grant_q   <= n_grant;
      rack_q    <= n_rack;
      idle_q    <= n_idle;
      rows_left <= n_rows;
      sr_sw     <= n_srsw;
      mrs_pend  <= n_mrsp;
      sr_keep   <= n_keep;
    end
  end

  assign sd_cmd       = cmd_q;
  assign sd_addr      = addr_q;
  assign sd_cke       = cke_q;
  assign refresh_busy = busy_q;
  assign acc_grant    = grant_q;
  assign rst_ack      = rack_q;
  assign idle         = idle_q;

endmodule

// File: rtl/sdram_pwr_seq_chk.sv
module sdram_pwr_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mode_reg_val,
  input logic              acc_grant,
  input logic              refresh_busy,
  input logic              rst_ack,
  input logic              idle,
  input logic              sd_cke,
  input logic [2:0]        sd_cmd,
  input logic [ADDR_W-1:0] sd_addr
);

  a_r1_cmd_code: assert property (@(posedge clk) disable iff (rst)
    sd_cmd <= 3'd4);

  a_r2_ref_busy: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd == 3'd2 && sd_cke) |-> refresh_busy);

  a_r5_busy_no_grant: assert property (@(posedge clk) disable iff (rst)
    refresh_busy |-> !acc_grant);

  a_r6_cke_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_cke) |-> (sd_cmd == 3'd2 || idle));

  a_r7_grant_cke: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> sd_cke);

  a_r8_ack_hold: assert property (@(posedge clk) disable iff (rst)
    rst_ack |=> rst_ack);

  a_r10_idle_cke: assert property (@(posedge clk) disable iff (rst)
    idle |-> !sd_cke);

  a_r11_mode_addr: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd == 3'd3 || sd_cmd == 3'd4) |-> (sd_addr == $past(mode_reg_val)));

endmodule

bind sdram_pwr_seq sdram_pwr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_reg_val(mode_reg_val),
  .acc_grant   (acc_grant),
  .refresh_busy(refresh_busy),
  .rst_ack     (rst_ack),
  .idle        (idle),
  .sd_cke      (sd_cke),
  .sd_cmd      (sd_cmd),
  .sd_addr     (sd_addr)
);

// File: tb/sim_sdram_pwr_seq.sv
module sim_sdram_pwr_seq;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_burst_sel = 2'b10;
  logic          cfg_rst_protect = 1'b0;
  logic          cfg_pd_en = 1'b0;
  logic          cfg_emrs_sel = 1'b0;
  logic          sw_sref_set = 1'b0;
  logic          mode_load = 1'b0;
  logic [AW-1:0] mode_reg_val = '0;
  logic          acc_req = 1'b0;
  logic          bank_open = 1'b0;
  logic          warm_rst_req = 1'b0;
  logic          acc_grant, refresh_busy, rst_ack, idle, sd_cke;
  logic [2:0]    sd_cmd;
  logic [AW-1:0] sd_addr;

  always #10 clk = ~clk;

  sdram_pwr_seq #(
    .ADDR_W(AW), .AP_BIT(10), .ROW_INT_CYC(40), .MAX_OWED(16),
    .TRP(2), .TRFC(3), .TXSR(4), .TMRD(2)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_burst_sel(cfg_burst_sel),
    .cfg_rst_protect(cfg_rst_protect), .cfg_pd_en(cfg_pd_en),
    .cfg_emrs_sel(cfg_emrs_sel), .sw_sref_set(sw_sref_set),
    .mode_load(mode_load), .mode_reg_val(mode_reg_val), .acc_req(acc_req),
    .bank_open(bank_open), .warm_rst_req(warm_rst_req),
    .acc_grant(acc_grant), .refresh_busy(refresh_busy), .rst_ack(rst_ack),
    .idle(idle), .sd_cke(sd_cke), .sd_cmd(sd_cmd), .sd_addr(sd_addr)
  );

  typedef struct {
    int    cmd;
    int    cke;
    bit    achk;
    int    addr;
    int    gap;
    string tag;
  } exp_t;

  exp_t q[$];
  int   nchk = 0;
  int   nerr = 0;
  int   cyc = 0;
  int   last_cyc = 0;
  bit   chk_grant = 1'b0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input int cmd, input int cke, input bit achk,
                            input int addr, input int gap, input string tag);
    exp_t e;
    e.cmd = cmd; e.cke = cke; e.achk = achk; e.addr = addr; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops expected commands as they appear on the pins
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      last_cyc = cyc;
    end else begin
      if (chk_grant && (refresh_busy || sd_cmd != 3'd0))
        chk_eq("R5 grant during refresh", int'(acc_grant), 0);
      if (sd_cmd != 3'd0) begin
        int gap;
        gap = cyc - last_cyc;
        last_cyc = cyc;
        if (sd_cmd == 3'd2 && sd_cke)
          chk_eq("R2 busy with refresh", int'(refresh_busy), 1);
        nchk++;
        if (q.size() == 0) begin
          nerr++;
          $display("FAIL unexpected command actual=%0d expected=none", sd_cmd);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (int'(sd_cmd) != e.cmd || int'(sd_cke) != e.cke ||
              (e.achk && int'(sd_addr) != e.addr) ||
              (e.gap != 0 && gap != e.gap)) begin
            nerr++;
            $display("FAIL %s actual cmd=%0d cke=%0d addr=%0h gap=%0d expected cmd=%0d cke=%0d addr=%0h gap=%0d",
                     e.tag, sd_cmd, sd_cke, sd_addr, gap, e.cmd, e.cke, e.addr, e.gap);
          end
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cfg_burst_sel = 2'b10; cfg_rst_protect = 1'b0; cfg_pd_en = 1'b0;
    cfg_emrs_sel = 1'b0; sw_sref_set = 1'b0; mode_load = 1'b0;
    mode_reg_val = '0; acc_req = 1'b0; bank_open = 1'b0; warm_rst_req = 1'b0;
    step(3);
    chk_eq("R1 cmd", int'(sd_cmd), 0);
    chk_eq("R1 cke", int'(sd_cke), 1);
    chk_eq("R1 busy", int'(refresh_busy), 0);
    chk_eq("R1 grant", int'(acc_grant), 0);
    chk_eq("R1 ack", int'(rst_ack), 0);
    chk_eq("R1 idle", int'(idle), 0);
    rst = 1'b0;
  endtask

  initial begin
    // R3: one-row bursts, 40 cycles apart
    do_reset();
    cfg_burst_sel = 2'b00;
    expect_cmd(2, 1, 0, 0, 0, "R3");
    expect_cmd(2, 1, 0, 0, 40, "R3");
    expect_cmd(2, 1, 0, 0, 40, "R3");
    step(130);
    chk_eq("R3 pending", q.size(), 0);

    // R2: four-row bursts, spacing TRFC and burst period 160
    do_reset();
    cfg_burst_sel = 2'b01;
    expect_cmd(2, 1, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) expect_cmd(2, 1, 0, 0, 3, "R2");
    expect_cmd(2, 1, 0, 0, 151, "R2");
    for (int i = 0; i < 3; i++) expect_cmd(2, 1, 0, 0, 3, "R2");
    step(340);
    chk_eq("R2 pending", q.size(), 0);
    chk_eq("R2 busy end", int'(refresh_busy), 0);

    // R4/R5: eight rows with open bank and access held
    do_reset();
    bank_open = 1'b1;
    acc_req = 1'b1;
    expect_cmd(1, 1, 1, 'h400, 0, "R4");
    expect_cmd(2, 1, 0, 0, 2, "R4");
    for (int i = 0; i < 7; i++) expect_cmd(2, 1, 0, 0, 3, "R2");
    step(100);
    chk_eq("R5 grant when free", int'(acc_grant), 1);
    chk_grant = 1'b1;
    step(260);
    chk_grant = 1'b0;
    chk_eq("R4 pending", q.size(), 0);

    // R6/R7: software self-refresh and exit on access
    do_reset();
    step(5);
    expect_cmd(2, 0, 0, 0, 0, "R6");
    sw_sref_set = 1'b1;
    step(1);
    sw_sref_set = 1'b0;
    step(400);
    chk_eq("R6 cke low", int'(sd_cke), 0);
    chk_eq("R6 pending", q.size(), 0);
    acc_req = 1'b1;
    step(1);
    chk_eq("R7 cke up", int'(sd_cke), 1);
    chk_eq("R7 no early grant", int'(acc_grant), 0);
    step(4);
    chk_eq("R7 grant before TXSR", int'(acc_grant), 0);
    step(1);
    chk_eq("R7 grant", int'(acc_grant), 1);
    acc_req = 1'b0;

    // R8: protected warm reset
    do_reset();
    bank_open = 1'b1;
    cfg_rst_protect = 1'b1;
    expect_cmd(1, 1, 1, 'h400, 0, "R8");
    expect_cmd(2, 0, 0, 0, 2, "R8");
    warm_rst_req = 1'b1;
    step(3);
    chk_eq("R8 ack waits", int'(rst_ack), 0);
    chk_eq("R8 cke low", int'(sd_cke), 0);
    step(1);
    chk_eq("R8 ack", int'(rst_ack), 1);
    acc_req = 1'b1;
    step(10);
    chk_eq("R8 no wake", int'(sd_cke), 0);
    chk_eq("R8 ack held", int'(rst_ack), 1);
    chk_eq("R8 pending", q.size(), 0);

    // R9: unprotected warm reset
    do_reset();
    warm_rst_req = 1'b1;
    step(1);
    chk_eq("R9 ack", int'(rst_ack), 1);
    chk_eq("R9 cke", int'(sd_cke), 1);
    step(10);
    chk_eq("R9 pending", q.size(), 0);

    // R10: power-down
    do_reset();
    cfg_pd_en = 1'b1;
    step(1);
    chk_eq("R10 cke low", int'(sd_cke), 0);
    chk_eq("R10 idle", int'(idle), 1);
    step(20);
    chk_eq("R10 stays down", int'(sd_cke), 0);
    acc_req = 1'b1;
    step(1);
    chk_eq("R10 wake cke", int'(sd_cke), 1);
    chk_eq("R10 wake idle", int'(idle), 0);
    chk_eq("R10 no grant yet", int'(acc_grant), 0);
    step(1);
    chk_eq("R10 grant", int'(acc_grant), 1);
    acc_req = 1'b0;
    step(1);
    chk_eq("R10 back down", int'(sd_cke), 0);
    chk_eq("R10 idle again", int'(idle), 1);

    // R11: mode and extended mode loads
    do_reset();
    mode_reg_val = 13'h0A5B;
    expect_cmd(3, 1, 1, 'h0A5B, 0, "R11");
    mode_load = 1'b1;
    step(1);
    mode_load = 1'b0;
    step(5);
    cfg_emrs_sel = 1'b1;
    mode_reg_val = 13'h1234;
    expect_cmd(4, 1, 1, 'h1234, 0, "R11");
    mode_load = 1'b1;
    step(1);
    mode_load = 1'b0;
    step(5);
    chk_eq("R11 pending", q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(150000 * 20);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule